// File: doc/BRIEF.md
# Four-Channel Free-Running Capture Timer

A 16-bit up-counter that, once its run control is raised, advances on every system clock cycle in which the count-clock enable is high. Four capture channels share this counter. Each channel watches its own external input, first taken through a two-flop synchronizer, for the edge kind that channel's select field enables. On a matching edge the channel copies the present count into its capture register and pulses its capture interrupt.

When the counter advances past its all-ones value it returns to zero and goes on counting. On that wrap it pulses an overflow interrupt and sets a sticky overflow flag, which stays set until software pulses the clear input. Dropping the run control returns the counter to zero and stops it; the capture registers keep their contents.

Top module: `capture_timer4`

## Requirements
- R1: While `run` is low the counter holds 0x0000. After `run` rises, counting starts from 0x0000.
- R2: While `run` is high the counter advances by one at each clock edge where `tick_en` is high. It holds its value at edges where `tick_en` is low.
- R3: A change of `cap_in[m]` first sampled at clock edge k that forms a selected edge is recorded at edge k+2. `cap_data[16m+15:16m]` takes the count held between edges k+1 and k+2, and `cap_irq[m]` is high for the cycle after edge k+2.
- R4: `edge_sel[2m+1:2m]` picks channel m's valid edges: 00 none, 01 rising, 10 falling, 11 both. An edge that is not selected changes neither `cap_irq[m]` nor `cap_data` for that channel.
- R5: The four channels work independently. Edges on several channels in the same cycle are all captured, each into its own register.
- R6: At an edge where the count is 0xFFFF and advances, the count becomes 0x0000 and counting continues. `ovf_irq` is high for the cycle after that edge.
- R7: `ovf_flag` becomes 1 at a wrap and stays 1 until an edge that samples `ovf_clr` high, after which it reads 0.
- R8: If `ovf_clr` is high at the same edge as a wrap, `ovf_flag` reads 1 afterwards.
- R9: Dropping `run` returns the count to 0x0000 at the next edge. The capture registers keep their values.
- R10: A capture recorded at the same edge as a wrap stores 0xFFFF.
- R11: `cap_irq` and `ovf_irq` are pulses that last one clock cycle for each event.
- R12: After reset all capture registers read 0, `ovf_flag` is 0 and no interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-clock enable, one count per high cycle |
| run | input | 1 | Counter run control |
| cap_in | input | 4 | Capture inputs, one per channel |
| edge_sel | input | 8 | Two-bit edge select per channel, channel m at [2m+1:2m] |
| ovf_clr | input | 1 | Clears the overflow flag |
| cap_data | output | 64 | Capture registers, channel m at [16m+15:16m] |
| cap_irq | output | 4 | Capture interrupt pulses |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A capture result is due two edges after the edge that first samples the pin change. The stored value is the count after the first of those two edges. An overflow pulse and the flag are due right after the wrapping edge, and a clear takes effect at the edge that samples it. The bench keeps its own count model, clocked on the same edge as the design. A driver marks each expected capture, and the model queues the expected value exactly one edge later, when it knows the count held before the capture edge. A monitor samples on the falling edge and matches every interrupt pulse to a queued item, so early, late, missing and extra results all show up as failures.

// File: rtl/capture_timer4.sv
module capture_timer4 #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run,
  input  logic [NCH-1:0]    cap_in,
  input  logic [2*NCH-1:0]  edge_sel,
  input  logic              ovf_clr,
  output logic [NCH*CW-1:0] cap_data,
  output logic [NCH-1:0]    cap_irq,
  output logic              ovf_irq,
  output logic              ovf_flag
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0]  cnt;
  logic [NCH-1:0] sy1, sy2, sy3, hit;
  logic [CW-1:0]  cap_q [NCH];

  wire wrap = run & tick_en & (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick_en) cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= cap_in; sy2 <= sy1; sy3 <= sy2;
    end

  for (genvar m = 0; m < NCH; m++) begin : g_ch
    assign hit[m] = (edge_sel[2*m]   &  sy2[m] & ~sy3[m]) |
                    (edge_sel[2*m+1] & ~sy2[m] &  sy3[m]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cap_q[m] <= '0;
      else if (hit[m]) cap_q[m] <= cnt;

    assign cap_data[m*CW +: CW] = cap_q[m];

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_irq[m] |-> $stable(cap_q[m])); // R4
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_irq  <= '0;
      ovf_irq  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      cap_irq <= hit;
      ovf_irq <= wrap;
      if (wrap)         ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end

  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && cnt != CMAX) |=> (cnt == CW'($past(cnt) + 1'b1))); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (cnt == '0)); // R6
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq); // R11
  AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R7
endmodule

// File: tb/capture_timer4_bench.sv
module capture_timer4_bench;
  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, run = 1'b0, ovf_clr = 1'b0;
  logic [3:0]  cap_in = '0;
  logic [7:0]  edge_sel = 8'hFF;
  logic [63:0] cap_data;
  logic [3:0]  cap_irq;
  logic        ovf_irq, ovf_flag;

  capture_timer4 u_capture_timer4 (.clk, .rst_n, .tick_en, .run, .cap_in, .edge_sel,
    .ovf_clr, .cap_data, .cap_irq, .ovf_irq, .ovf_flag);

  always #2 clk = ~clk;

  int errs = 0, checks = 0;
  int          q_ch[$];
  logic [15:0] q_val[$];
  string       q_tag[$];
  logic [15:0] ref_cnt;
  logic [15:0] nxt;
  logic [3:0]  req = '0, pend;
  string       req_tag[4], pend_tag[4];
  string       ovf_tag = "R6";

  task automatic chk(bit ok, string r, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic void push(int ch, logic [15:0] v, string t);
    q_ch.push_back(ch); q_val.push_back(v); q_tag.push_back(t);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_cnt <= '0; pend <= '0;
    end else begin
      nxt = !run ? 16'h0 : tick_en ? ref_cnt + 16'h1 : ref_cnt;
      if (run && tick_en && ref_cnt == 16'hFFFF) push(4, 16'h0, ovf_tag);
      for (int m = 0; m < 4; m++) if (pend[m]) push(m, nxt, pend_tag[m]);
      pend <= req;
      for (int m = 0; m < 4; m++) pend_tag[m] <= req_tag[m];
      ref_cnt <= nxt;
    end

  task automatic pop_check(int ch, logic [15:0] act, logic flag);
    int idx = -1;
    for (int i = 0; i < q_ch.size(); i++) if (idx < 0 && q_ch[i] == ch) idx = i;
    if (idx < 0) begin
      chk(1'b0, ch == 4 ? "R6 unexpected overflow" : "R4 unexpected capture", ch, 99);
      return;
    end
    if (ch == 4) chk(flag == 1'b1, q_tag[idx], flag, 1);
    else         chk(act == q_val[idx], q_tag[idx], act, q_val[idx]);
    q_ch.delete(idx); q_val.delete(idx); q_tag.delete(idx);
  endtask

  always @(negedge clk)
    if (rst_n) begin
      for (int m = 0; m < 4; m++) if (cap_irq[m]) pop_check(m, cap_data[m*16 +: 16], 1'b0);
      if (ovf_irq) pop_check(4, 16'h0, ovf_flag);
    end

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      req = '0;
    end
  endtask

  task automatic toggle(int m, bit expect_cap, string t);
    cap_in[m] = ~cap_in[m];
    if (expect_cap) begin
      req[m] = 1'b1; req_tag[m] = t;
    end
  endtask

  task automatic main_seq();
    logic [63:0] saved;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(cap_data == '0, "R12 capture regs", cap_data, 0);
    chk(ovf_flag == 1'b0, "R12 flag", ovf_flag, 0);
    chk({cap_irq, ovf_irq} == '0, "R12 irqs", {cap_irq, ovf_irq}, 0);

    toggle(0, 1, "R1 hold while stopped"); step(6);
    run = 1'b1; step(10);

    toggle(1, 1, "R3 capture value"); step(3);
    chk(cap_irq[1] == 1'b1, "R3 irq at k+2", cap_irq[1], 1);
    step(1);
    chk(cap_irq[1] == 1'b0, "R11 capture pulse width", cap_irq[1], 0);
    step(4);

    edge_sel[5:4] = 2'b01;
    toggle(2, 1, "R4 rising only"); step(5);
    saved = cap_data;
    toggle(2, 0, ""); step(5);
    chk(cap_data[47:32] == saved[47:32], "R4 falling ignored", cap_data[47:32], saved[47:32]);
    edge_sel[5:4] = 2'b10;
    toggle(2, 0, ""); step(5);
    chk(cap_data[47:32] == saved[47:32], "R4 rising ignored", cap_data[47:32], saved[47:32]);
    toggle(2, 1, "R4 falling only"); step(5);
    edge_sel[5:4] = 2'b00;
    saved = cap_data;
    toggle(2, 0, ""); step(5);
    toggle(2, 0, ""); step(5);
    chk(cap_data[47:32] == saved[47:32], "R4 none selected", cap_data[47:32], saved[47:32]);
    edge_sel[5:4] = 2'b11;
    toggle(2, 1, "R4 both rise"); step(5);
    toggle(2, 1, "R4 both fall"); step(5);

    for (int i = 0; i < 8; i++) begin
      tick_en = i[0];
      if (i == 3) toggle(3, 1, "R2 gated tick");
      step(1);
    end
    tick_en = 1'b0;
    toggle(3, 1, "R2 hold"); step(6);
    toggle(3, 1, "R2 hold again"); step(6);
    tick_en = 1'b1; step(3);

    for (int m = 0; m < 4; m++) toggle(m, 1, "R5 simultaneous");
    step(8);

    saved = cap_data;
    run = 1'b0; step(3);
    chk(cap_data == saved, "R9 captures kept", cap_data, saved);
    toggle(1, 1, "R9 counter cleared"); step(6);
    run = 1'b1;

    while (ref_cnt != 16'hFFFD) step(1);
    toggle(0, 1, "R10 capture at wrap");
    step(6);
    chk(cap_data[15:0] == 16'hFFFF, "R10 wrap value", cap_data[15:0], 16'hFFFF);
    chk(ovf_flag == 1'b1, "R7 flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk(ovf_flag == 1'b0, "R7 flag cleared", ovf_flag, 0);

    ovf_tag = "R8 set wins";
    while (ref_cnt != 16'hFFFF) step(1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk(ovf_flag == 1'b1, "R8 set over clear", ovf_flag, 1);
    chk(ovf_irq == 1'b1, "R6 overflow pulse", ovf_irq, 1);
    step(1);
    chk(ovf_irq == 1'b0, "R11 overflow pulse width", ovf_irq, 0);
    step(3);
    chk(ovf_flag == 1'b1, "R7 flag still set", ovf_flag, 1);
    chk(q_ch.size() == 0, "R3 missing results", q_ch.size(), 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule